// File: doc/BRIEF.md
# Configurable Clock Fan-Out Control

This block takes one reference clock and spreads it over six output pairs and one feedback line. Each pair has a true output and a companion output. A mode input picks how the companion behaves. In double-data-rate mode it carries the inverted reference, so the pair forms a differential clock. In standard SDRAM mode it carries a second in-phase copy, so the block gives twelve identical single-ended clocks.

Each pair has its own enable bit, and the feedback line has one too. A configuration register block outside this design drives these bits. Its reset value should be all ones, so that every output runs after power-up. An active-low power-down input overrides every enable bit and the mode, and holds all thirteen outputs low.

The gating is purely combinational, with no state. Mode and power-down are meant as static levels. There is no data stream here, so every pin is a plain control or clock line, and none has a valid/ready handshake.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: With power-down deasserted (`pwr_dn_n`=1) and `pair_en[i]`=1, `clk_true[i]` equals `ref_clk` in both phases, in either mode.
- R2: With `ddr_mode`=1, power-down deasserted and `pair_en[i]`=1, `clk_comp[i]` equals the inverse of `ref_clk`.
- R3: With `ddr_mode`=0, power-down deasserted and `pair_en[i]`=1, `clk_comp[i]` equals `ref_clk`.
- R4: While `pwr_dn_n`=0, all six `clk_true` bits, all six `clk_comp` bits and `fb_clk` are 0 in both clock phases. This holds whatever the enables and the mode are.
- R5: With power-down deasserted and `pair_en[i]`=0, both `clk_true[i]` and `clk_comp[i]` are 0 in both phases. This includes DDR mode, where the companion output is held low, not high.
- R6: With power-down deasserted, `fb_clk` equals `ref_clk` when `fb_en`=1 and is 0 when `fb_en`=0.
- R7: Enable bit `pair_en[i]` affects only pair `i`. The other pairs and `fb_clk` are unaffected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock to distribute |
| ddr_mode | input | 1 | 1 = companion outputs inverted (DDR), 0 = in-phase (SDRAM) |
| pwr_dn_n | input | 1 | Active-low power-down; forces every output low |
| pair_en | input | NUM_PAIRS (6) | Per-pair enable, bit i gates pair i |
| fb_en | input | 1 | Feedback output enable |
| clk_true | output | NUM_PAIRS (6) | True output of each pair |
| clk_comp | output | NUM_PAIRS (6) | Companion output of each pair |
| fb_clk | output | 1 | Feedback clock |

## Verification
Three controls can act on the same pair companion in the same cycle: the DDR inversion, a cleared pair enable and power-down. When the enable is cleared in DDR mode, the inversion would drive the companion high, so a disabled pair must still read low. The bench sweeps every combination of mode, power-down, the six pair enables and the feedback enable. A driver queues the expected high-phase and low-phase values for each combination. A monitor samples all thirteen outputs in the middle of each phase and compares them with those values. A companion that reads high while disabled, or while powered down, in DDR mode counts as a failure.

// File: rtl/fanout_pkg.sv
package fanout_pkg;
  typedef enum logic {
    MODE_SDR = 1'b0,
    MODE_DDR = 1'b1
  } pair_mode_e;

  localparam int unsigned DEFAULT_PAIRS = 6;
endpackage

// File: rtl/fanout_gate_cell.sv
module fanout_gate_cell (
  input  logic clk_in,
  input  logic allow,
  output logic clk_out
);
  // Output is low while the gate is closed, never held high.
  assign clk_out = clk_in & allow;
endmodule

// File: rtl/fanout_pair.sv
module fanout_pair
  import fanout_pkg::*;
(
  input  logic       ref_clk,
  input  pair_mode_e mode,
  input  logic       allow,
  output logic       out_true,
  output logic       out_comp
);
  logic comp_src;

  // The polarity is chosen before the gate, so that a closed gate holds the companion low.
  always_comb begin
    unique case (mode)
      MODE_DDR: comp_src = ~ref_clk;
      default:  comp_src = ref_clk;
    endcase
  end

  fanout_gate_cell u_gate_true (
    .clk_in (ref_clk),
    .allow  (allow),
    .clk_out(out_true)
  );

  fanout_gate_cell u_gate_comp (
    .clk_in (comp_src),
    .allow  (allow),
    .clk_out(out_comp)
  );
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import fanout_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = DEFAULT_PAIRS
) (
  input  logic                 ref_clk,
  input  logic                 ddr_mode,
  input  logic                 pwr_dn_n,
  input  logic [NUM_PAIRS-1:0] pair_en,
  input  logic                 fb_en,
  output logic [NUM_PAIRS-1:0] clk_true,
  output logic [NUM_PAIRS-1:0] clk_comp,
  output logic                 fb_clk
);
  localparam int unsigned NUM_OUTS = 2 * NUM_PAIRS + 1;

  pair_mode_e           mode_sel;
  logic [NUM_PAIRS-1:0] pair_allow;
  logic                 fb_allow;

  assign mode_sel = pair_mode_e'(ddr_mode);

  // Power-down has the highest priority and overrides every enable bit.
  assign pair_allow = pair_en & {NUM_PAIRS{pwr_dn_n}};
  assign fb_allow   = fb_en & pwr_dn_n;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    fanout_pair u_pair (
      .ref_clk (ref_clk),
      .mode    (mode_sel),
      .allow   (pair_allow[g]),
      .out_true(clk_true[g]),
      .out_comp(clk_comp[g])
    );
  end

  fanout_gate_cell u_gate_fb (
    .clk_in (ref_clk),
    .allow  (fb_allow),
    .clk_out(fb_clk)
  );

  // Checks between the control inputs and the outputs of the generated slices
  logic [NUM_OUTS-1:0] all_outs;
  assign all_outs = {fb_clk, clk_comp, clk_true};

  always_comb begin
    p_pwrdn_all_low_r4: assert (pwr_dn_n || (all_outs == '0));
    p_fb_gated_r6: assert (fb_en || !fb_clk);
    p_fb_follow_r6: assert (!(fb_en && pwr_dn_n) || (fb_clk == ref_clk));
  end

  for (genvar a = 0; a < NUM_PAIRS; a++) begin : g_chk
    always_comb begin
      p_disabled_low_r5: assert (pair_en[a] || (!clk_true[a] && !clk_comp[a]));
      p_true_follow_r1: assert (!(pair_en[a] && pwr_dn_n) || (clk_true[a] == ref_clk));
      p_ddr_inverse_r2: assert (!(ddr_mode && pair_en[a] && pwr_dn_n) || (clk_comp[a] != clk_true[a]));
      p_sdr_copy_r3: assert (ddr_mode || (clk_comp[a] == clk_true[a]));
    end
  end
endmodule

// File: tb/clk_fanout_ctrl_test.sv
module clk_fanout_ctrl_test;
  localparam int NP = 6;
  localparam time HALF = 10ns;

  typedef struct {
    logic [NP-1:0] t;
    logic [NP-1:0] c;
    logic          fb;
    string         tag;
  } exp_item_t;

  logic          clk = 1'b0;
  logic          ddr_mode = 1'b1;
  logic          pwr_dn_n = 1'b0;
  logic [NP-1:0] pair_en = '1;
  logic          fb_en = 1'b1;
  logic [NP-1:0] clk_true, clk_comp;
  logic          fb_clk;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  exp_item_t q[$];

  always #(HALF) clk = ~clk;

  clk_fanout_ctrl #(.NUM_PAIRS(NP)) uut (
    .ref_clk (ref_wire),
    .ddr_mode(ddr_mode),
    .pwr_dn_n(pwr_dn_n),
    .pair_en (pair_en),
    .fb_en   (fb_en),
    .clk_true(clk_true),
    .clk_comp(clk_comp),
    .fb_clk  (fb_clk)
  );
  wire ref_wire = clk;

  task automatic check(string req, logic [NP:0] act, logic [NP:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic compare(exp_item_t e);
    check({e.tag, " true outputs (R1/R5/R7)"}, {1'b0, clk_true}, {1'b0, e.t});
    check({e.tag, " companion outputs (R2/R3/R5)"}, {1'b0, clk_comp}, {1'b0, e.c});
    check({e.tag, " feedback R6"}, {NP'(0), fb_clk}, {NP'(0), e.fb});
  endtask

  function automatic exp_item_t model(logic ph, logic ddr, logic pdn, logic [NP-1:0] en, logic fbe);
    exp_item_t e;
    logic [NP-1:0] live;
    live = en & {NP{pdn}};
    e.t  = live & {NP{ph}};
    e.c  = live & {NP{ddr ? ~ph : ph}};
    e.fb = fbe & pdn & ph;
    e.tag = !pdn ? "R4" : (ddr ? "R2" : "R3");
    return e;
  endfunction

  // Driver: changes the inputs just after each rising edge and queues the expected high- and low-phase values.
  initial begin
    #(HALF/2);
    check("R4 reset low phase", {fb_clk, clk_true}, '0);
    check("R4 reset low phase comp", {1'b0, clk_comp}, '0);
    #(HALF);
    check("R4 reset high phase", {fb_clk, clk_true}, '0);
    check("R4 reset high phase comp", {1'b0, clk_comp}, '0);
    for (int m = 0; m < 2; m++) begin
      for (int pd = 0; pd < 2; pd++) begin
        for (int p = 0; p < 128; p++) begin
          @(posedge clk);
          #1ns;
          ddr_mode = m[0];
          pwr_dn_n = pd[0];
          pair_en  = p[NP-1:0];
          fb_en    = p[NP];
          q.push_back(model(1'b1, m[0], pd[0], p[NP-1:0], p[NP]));
          q.push_back(model(1'b0, m[0], pd[0], p[NP-1:0], p[NP]));
        end
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  // Monitor: samples in the middle of each phase and pops the matching expected item.
  initial begin
    forever begin
      @(posedge clk);
      #(HALF/2);
      if (q.size() >= 2) begin
        compare(q.pop_front());
        @(negedge clk);
        #(HALF/2);
        compare(q.pop_front());
      end
    end
  end

  initial begin
    fork
      wait (done);
      #(200000 * 2 * HALF);
    join_any
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule